// File: doc/BRIEF.md
# Synchronous Serial Port with Master and Slave Operation

This block is an 8-bit synchronous serial port that can run either as the clock-driving master or as a slave clocked from an external pin. Software controls it through one 8-bit control register and one data buffer on a small register bus. When software writes the buffer, the value is loaded into an internal shift register. When a byte finishes, the received value is placed in the buffer and a buffer-full flag is raised. Reading the buffer clears that flag.

In master mode the serial clock comes from one of three system-clock prescale ratios, or it toggles once per tick of an external timer. In slave mode the serial clock, data-in and select pins are synchronised into the system clock domain. The select pin can be honoured or ignored, depending on the mode. The idle level of the serial clock is selectable.

Two sticky error flags live in the control register. The collision flag records a buffer write made while a byte is in flight. The overflow flag records a slave byte that completed while the previous byte was still unread.

Top module: `spi_port`

## Requirements
- R1: After reset the control register reads 0x00, buf_full is 0, and sck_oe, sdo_oe and pins_en are all 0.
- R2: The control register (bus_addr 0) has this layout: bit 7 collision flag, bit 6 overflow flag, bit 5 port enable, bit 4 clock idle level, bits 3:0 mode. A write reads back unchanged. The buffer is at bus_addr 1.
- R3: Mode 0 gives an SCK period of 4 system clocks, mode 1 gives 16, and mode 2 gives 64. Each half period is half of that value.
- R4: In mode 3 the master SCK toggles once on every cycle in which tmr_tick is high while a transfer runs. The SCK period is therefore two tick intervals.
- R5: A transfer is 8 bits, MSB first. sdo_o changes on the leading SCK edge (the edge leaving the idle level), and the input is sampled on the trailing edge. In master mode buf_full rises in the same cycle as the eighth trailing edge. A buffer read (bus_rd with bus_addr 1) clears buf_full.
- R6: While no master transfer runs, sck_o equals the idle level in bit 4.
- R7: A buffer write during a transfer sets bit 7 and is ignored, so the byte in flight is unchanged. Bit 7 stays set until software writes it to 0.
- R8: In slave mode, a byte that completes while buf_full is 1 sets bit 6 and is discarded. The buffer keeps the old byte.
- R9: In master modes (0 to 3) bit 6 is never set by hardware. A new byte overwrites an unread buffer.
- R10: In mode 4, a high ss_n_i forces sdo_oe to 0 and abandons a partial byte. In mode 5, ss_n_i is ignored.
- R11: sck_oe is 1 exactly when the port is enabled in a master mode. sdo_oe is 1 in enabled master modes and in selected slave modes. When bit 5 is 0, pins_en, sck_oe and sdo_oe are all 0.
- R12: Mode codes 6 to 15 drive no pin, run no transfer and set no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 1 | 0 selects the control register, 1 selects the data buffer |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; a buffer read clears buf_full |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the selected register |
| buf_full | output | 1 | Set when a received byte is loaded into the buffer |
| sck_i | input | 1 | Serial clock from the pin (slave) |
| sck_o | output | 1 | Serial clock to the pin (master) |
| sck_oe | output | 1 | Drive enable for the clock pin |
| sdi_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial data out |
| sdo_oe | output | 1 | Drive enable for the data-out pin |
| ss_n_i | input | 1 | Active-low slave select |
| tmr_tick | input | 1 | Timer tick for the timer-clocked master mode |
| pins_en | output | 1 | High while the port owns its pins |

## Verification
The hardest states to reach from the ports are a partially shifted slave byte cut off by a rising select, and a slave byte that completes on top of an unread buffer. The bench reaches the first by driving only three SCK pulses and then raising ss_n_i. It then shows that the partial byte was discarded: a fresh buffer write is accepted without a collision, and the next full byte arrives intact. The bench reaches overflow by skipping the buffer read between two slave bytes. Collision is provoked by a second buffer write a few cycles into a master byte, while the bench's model partner keeps clocking the original data.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;

   typedef struct packed {
      logic       wcol;
      logic       sov;
      logic       en;
      logic       ckp;
      logic [3:0] mode;
   } ctrl_t;

   localparam logic [3:0] MODE_S_SEL   = 4'd4;
   localparam logic [3:0] MODE_S_NOSEL = 4'd5;

   function automatic logic mode_is_master(input logic [3:0] m);
      return m <= 4'd3;
   endfunction

   function automatic logic mode_is_slave(input logic [3:0] m);
      return (m == MODE_S_SEL) || (m == MODE_S_NOSEL);
   endfunction

endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
   parameter int          STAGES  = 2,
   parameter int          W       = 1,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (STAGES < 1) begin : g_bad_stages
      $fatal(1, "spi_sync: STAGES must be at least 1");
   end

   if (STAGES == 1) begin : g_single
      logic [W-1:0] r;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) r <= RST_VAL;
         else        r <= d;
      end
      assign q = r;
   end else begin : g_chain
      logic [STAGES*W-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= {STAGES{RST_VAL}};
         else        chain <= {chain[(STAGES-1)*W-1:0], d};
      end
      assign q = chain[STAGES*W-1 -: W];
   end

endmodule

// File: rtl/spi_sck_gen.sv
module spi_sck_gen #(
   parameter int PRE_A = 4,
   parameter int PRE_B = 16,
   parameter int PRE_C = 64
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       run,
   input  logic [1:0] sel,
   input  logic       tmr_tick,
   output logic       half_tick
);

   localparam int HALF_A = PRE_A / 2;
   localparam int HALF_B = PRE_B / 2;
   localparam int HALF_C = PRE_C / 2;
   localparam int HALF_MAX = (HALF_A > HALF_B) ? ((HALF_A > HALF_C) ? HALF_A : HALF_C)
                                               : ((HALF_B > HALF_C) ? HALF_B : HALF_C);
   localparam int CW = $clog2(HALF_MAX) + 1;

   if (PRE_A < 4 || PRE_B < 4 || PRE_C < 4 ||
       (PRE_A % 2) != 0 || (PRE_B % 2) != 0 || (PRE_C % 2) != 0) begin : g_bad_ratio
      $fatal(1, "spi_sck_gen: prescale ratios must be even and at least 4");
   end

   logic [CW-1:0] cnt;
   logic [CW-1:0] limit;
   logic          use_timer;

   assign use_timer = (sel == 2'd3);

   always_comb begin
      case (sel)
         2'd0:    limit = CW'(HALF_A - 1);
         2'd1:    limit = CW'(HALF_B - 1);
         default: limit = CW'(HALF_C - 1);
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   cnt <= '0;
      else if (!run || use_timer)   cnt <= '0;
      else if (cnt == limit)        cnt <= '0;
      else                          cnt <= cnt + 1'b1;
   end

   assign half_tick = run & (use_timer ? tmr_tick : (cnt == limit));

   // R3: a prescaled half period spans at least two system clocks
   assert_tick_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !use_timer && half_tick) |=> !half_tick);

endmodule

// File: rtl/spi_shifter.sv
module spi_shifter #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         load,
   input  logic [W-1:0] load_data,
   input  logic         lead,
   input  logic         trail,
   input  logic         sdi,
   output logic         sdo,
   output logic         done,
   output logic [W-1:0] rx_data,
   output logic         active
);

   localparam int CW = $clog2(W);

   if (W < 2) begin : g_bad_width
      $fatal(1, "spi_shifter: W must be at least 2");
   end

   logic [W-1:0]  sr;
   logic [CW-1:0] cnt;
   logic          sdo_r;
   logic          act_r;

   assign rx_data = {sr[W-2:0], sdi};
   assign done    = trail & act_r & (cnt == CW'(W - 1));
   assign sdo     = sdo_r;
   assign active  = act_r;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr    <= '0;
         cnt   <= '0;
         sdo_r <= 1'b0;
         act_r <= 1'b0;
      end else if (clr) begin
         cnt   <= '0;
         act_r <= 1'b0;
      end else if (load) begin
         sr    <= load_data;
         cnt   <= '0;
         act_r <= 1'b0;
      end else begin
         if (lead) begin
            sdo_r <= sr[W-1];
            act_r <= 1'b1;
         end
         if (trail && act_r) begin
            sr <= rx_data;
            if (done) begin
               cnt   <= '0;
               act_r <= 1'b0;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
      end
   end

   // R5: a leading edge arms the byte, the last trailing edge closes it
   assert_lead_arms_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (lead && !clr && !load) |=> act_r);
   assert_done_rearms_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !clr) |=> (!act_r && cnt == '0));

endmodule

// File: rtl/spi_port.sv
module spi_port
   import spi_port_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int PRE_A       = 4,
   parameter int PRE_B       = 16,
   parameter int PRE_C       = 64,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       bus_addr,
   input  logic       bus_wr,
   input  logic       bus_rd,
   input  logic [7:0] bus_wdata,
   output logic [7:0] bus_rdata,
   output logic       buf_full,
   input  logic       sck_i,
   output logic       sck_o,
   output logic       sck_oe,
   input  logic       sdi_i,
   output logic       sdo_o,
   output logic       sdo_oe,
   input  logic       ss_n_i,
   input  logic       tmr_tick,
   output logic       pins_en
);

   if (DATA_W < 2 || DATA_W > 8) begin : g_bad_data_w
      $fatal(1, "spi_port: DATA_W must lie in 2..8");
   end

   ctrl_t             ctrl;
   logic [DATA_W-1:0] rx_buf;
   logic              full_r;
   logic              busy_m;
   logic              sck_m;
   logic              sck_prev;

   logic              master, slave, slave_sel;
   logic              ss_s, sck_s, sdi_s;
   logic [2:0]        sync_q;
   logic              half_tick;
   logic              lead, trail, sdi_mux;
   logic              wr_ctl, wr_buf, rd_buf;
   logic              xfer_busy, accept, collide, sh_clr;
   logic              sh_done, sh_active, sh_sdo;
   logic [DATA_W-1:0] sh_rx;
   logic              ovf_evt;

   assign master = ctrl.en & mode_is_master(ctrl.mode);
   assign slave  = ctrl.en & mode_is_slave(ctrl.mode);

   spi_sync #(.STAGES(SYNC_STAGES), .W(3), .RST_VAL(3'b100)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({ss_n_i, sck_i, sdi_i}),
      .q     (sync_q)
   );
   assign ss_s  = sync_q[2];
   assign sck_s = sync_q[1];
   assign sdi_s = sync_q[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sck_prev <= 1'b0;
      else        sck_prev <= sck_s;
   end

   assign slave_sel = slave & ((ctrl.mode == MODE_S_NOSEL) | !ss_s);

   spi_sck_gen #(.PRE_A(PRE_A), .PRE_B(PRE_B), .PRE_C(PRE_C)) u_gen (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (busy_m & master),
      .sel       (ctrl.mode[1:0]),
      .tmr_tick  (tmr_tick),
      .half_tick (half_tick)
   );

   always_comb begin
      if (master) begin
         lead    = half_tick & (sck_m == ctrl.ckp);
         trail   = half_tick & (sck_m != ctrl.ckp);
         sdi_mux = sdi_i;
      end else begin
         lead    = slave_sel & (sck_s != ctrl.ckp) & (sck_prev == ctrl.ckp);
         trail   = slave_sel & (sck_s == ctrl.ckp) & (sck_prev != ctrl.ckp);
         sdi_mux = sdi_s;
      end
   end

   assign wr_ctl    = bus_wr & !bus_addr;
   assign wr_buf    = bus_wr &  bus_addr;
   assign rd_buf    = bus_rd &  bus_addr;
   assign xfer_busy = master ? busy_m : sh_active;
   assign accept    = wr_buf & (master | slave) & !xfer_busy;
   assign collide   = wr_buf & (master | slave) &  xfer_busy;
   assign sh_clr    = !(master | slave) | (slave & (ctrl.mode == MODE_S_SEL) & ss_s);

   spi_shifter #(.W(DATA_W)) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (sh_clr),
      .load      (accept),
      .load_data (bus_wdata[DATA_W-1:0]),
      .lead      (lead),
      .trail     (trail),
      .sdi       (sdi_mux),
      .sdo       (sh_sdo),
      .done      (sh_done),
      .rx_data   (sh_rx),
      .active    (sh_active)
   );

   assign ovf_evt = sh_done & slave & full_r & !rd_buf;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_m <= 1'b0;
         sck_m  <= 1'b0;
      end else begin
         if (!master)      busy_m <= 1'b0;
         else if (accept)  busy_m <= 1'b1;
         else if (sh_done) busy_m <= 1'b0;

         if (!master || !busy_m) sck_m <= ctrl.ckp;
         else if (half_tick)     sck_m <= ~sck_m;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl   <= '0;
         rx_buf <= '0;
         full_r <= 1'b0;
      end else begin
         if (wr_ctl)  ctrl      <= ctrl_t'(bus_wdata);
         if (collide) ctrl.wcol <= 1'b1;
         if (ovf_evt) ctrl.sov  <= 1'b1;

         if (sh_done && !ovf_evt) begin
            rx_buf <= sh_rx;
            full_r <= 1'b1;
         end else if (rd_buf) begin
            full_r <= 1'b0;
         end
      end
   end

   assign bus_rdata = bus_addr ? 8'(rx_buf) : ctrl;
   assign buf_full  = full_r;
   assign sck_o     = (master & busy_m) ? sck_m : ctrl.ckp;
   assign sck_oe    = master;
   assign sdo_o     = sh_sdo;
   assign sdo_oe    = master | slave_sel;
   assign pins_en   = master | slave;

   // R6: the clock is back at its idle level once a master byte closes
   assert_idle_after_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (sh_done && master && !wr_ctl) |=> (sck_o == ctrl.ckp));
   // R7: the collision flag holds until software writes the register
   assert_wcol_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl.wcol && !wr_ctl) |=> ctrl.wcol);
   // R8: an overflowed byte leaves buffer and full flag untouched
   assert_ovf_keeps_buffer_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_evt |=> ($stable(rx_buf) && full_r));
   // R9: hardware never raises overflow in a master mode
   assert_master_no_ovf_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (master && !wr_ctl) |=> !$rose(ctrl.sov));
   // R10: a deselected slave abandons its partial byte
   assert_deselect_abandons_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (slave && ctrl.mode == MODE_S_SEL && ss_s && !wr_ctl) |=> !sh_active);

endmodule

// File: tb/spi_port_test.sv
module spi_port_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_addr = 1'b1;
   logic       bus_wr = 1'b0;
   logic       bus_rd = 1'b0;
   logic [7:0] bus_wdata = 8'h00;
   logic [7:0] bus_rdata;
   logic       buf_full;
   logic       sck_i = 1'b0;
   logic       sck_o, sck_oe;
   logic       sdi_i = 1'b0;
   logic       sdo_o, sdo_oe;
   logic       ss_n_i = 1'b0;
   logic       tmr_tick = 1'b0;
   logic       pins_en;

   always #5 clk = ~clk;

   spi_port uut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .buf_full(buf_full),
      .sck_i(sck_i), .sck_o(sck_o), .sck_oe(sck_oe), .sdi_i(sdi_i), .sdo_o(sdo_o),
      .sdo_oe(sdo_oe), .ss_n_i(ss_n_i), .tmr_tick(tmr_tick), .pins_en(pins_en)
   );

   int         checks = 0;
   int         errors = 0;
   int         cyc = 0;
   bit         finished = 0;
   logic [7:0] model_ctrl = 8'h00;
   bit         mon_on = 0;
   bit         m_busy = 0;
   bit         m_en;
   int         bitidx = 0;
   logic [7:0] partner = 8'h00;
   logic [7:0] cap = 8'h00;
   int         exp_half = 0;
   int         last_toggle = 0;
   bit         have_last = 0;
   logic       prev_sck = 1'b0;
   logic [7:0] got;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   task automatic bus_write(input logic a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(posedge clk);
      if (!a) model_ctrl = d;
      @(negedge clk);
      bus_wr = 1'b0; bus_addr = 1'b1;
   endtask

   task automatic read_check(input logic a, input logic [7:0] exp, input string req);
      @(negedge clk);
      bus_addr = a;
      #1;
      check(bus_rdata === exp, req, int'(bus_rdata), int'(exp));
      bus_addr = 1'b1;
   endtask

   task automatic buf_pop();
      @(negedge clk);
      bus_addr = 1'b1; bus_rd = 1'b1;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic master_start(input logic [7:0] tx, input logic [7:0] pr, input int half);
      partner = pr; exp_half = half; bitidx = 0; have_last = 0; cap = 8'h00;
      m_busy = 1;
      bus_write(1'b1, tx);
   endtask

   task automatic slave_bits(input logic [7:0] din, input int nbits, input int half,
                             output logic [7:0] dout);
      dout = 8'h00;
      for (int i = 0; i < nbits; i++) begin
         @(negedge clk);
         sck_i = ~model_ctrl[4];
         sdi_i = din[7-i];
         repeat (half) @(negedge clk);
         dout = {dout[6:0], sdo_o};
         sck_i = model_ctrl[4];
         repeat (half) @(negedge clk);
      end
      repeat (6) @(negedge clk);
   endtask

   // timer tick: one cycle high every five cycles
   initial begin
      forever begin
         repeat (4) @(negedge clk);
         tmr_tick = 1'b1;
         @(negedge clk);
         tmr_tick = 1'b0;
      end
   end

   // per-clock reference model of the master clock and the partner device
   initial begin
      forever begin
         @(negedge clk);
         cyc++;
         if (mon_on) begin
            m_en = model_ctrl[5] && (model_ctrl[3:0] <= 4'd3);
            check(sck_oe === m_en, "R11 sck_oe", int'(sck_oe), int'(m_en));
            if (m_en && m_busy && sck_o !== prev_sck) begin
               if (have_last && exp_half > 0)
                  check(cyc - last_toggle == exp_half, "R3 R4 half period",
                        cyc - last_toggle, exp_half);
               last_toggle = cyc;
               have_last = 1;
               if (sck_o !== model_ctrl[4]) begin
                  sdi_i = partner[7-bitidx];
               end else begin
                  cap = {cap[6:0], sdo_o};
                  bitidx++;
                  if (bitidx == 8) begin
                     check(buf_full === 1'b1, "R5 full at last edge", int'(buf_full), 1);
                     m_busy = 0;
                     have_last = 0;
                  end
               end
            end else if (m_en && !m_busy) begin
               check(sck_o === model_ctrl[4], "R6 idle level", int'(sck_o), int'(model_ctrl[4]));
            end
         end
         prev_sck = sck_o;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog: actual still running expected finished (cycle %0d)", cyc);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      read_check(1'b0, 8'h00, "R1 ctrl");
      check(buf_full === 1'b0, "R1 buf_full", int'(buf_full), 0);
      check(sck_oe === 1'b0 && sdo_oe === 1'b0 && pins_en === 1'b0, "R1 pins",
            int'({sck_oe, sdo_oe, pins_en}), 0);
      mon_on = 1;

      // master, mode 0
      bus_write(1'b0, 8'h20);
      read_check(1'b0, 8'h20, "R2 readback");
      check(sdo_oe === 1'b1 && pins_en === 1'b1, "R11 master oe", int'({sdo_oe, pins_en}), 3);
      master_start(8'hA5, 8'h3C, 2);
      wait (!m_busy);
      check(cap === 8'hA5, "R5 master tx", int'(cap), 'hA5);
      read_check(1'b1, 8'h3C, "R5 master rx");
      buf_pop();
      check(buf_full === 1'b0, "R5 read clears", int'(buf_full), 0);

      // master, mode 1, idle high
      bus_write(1'b0, 8'h31);
      master_start(8'h5A, 8'hC3, 8);
      wait (!m_busy);
      check(cap === 8'h5A, "R3 mode1 tx", int'(cap), 'h5A);
      read_check(1'b1, 8'hC3, "R3 mode1 rx");

      // master, mode 2, buffer left unread
      bus_write(1'b0, 8'h22);
      master_start(8'h0F, 8'h96, 32);
      wait (!m_busy);
      read_check(1'b1, 8'h96, "R9 overwrite");
      read_check(1'b0, 8'h22, "R9 no overflow");
      buf_pop();

      // master, timer clock
      bus_write(1'b0, 8'h23);
      master_start(8'hF0, 8'h81, 5);
      wait (!m_busy);
      check(cap === 8'hF0, "R4 timer tx", int'(cap), 'hF0);
      read_check(1'b1, 8'h81, "R4 timer rx");
      buf_pop();

      // write collision
      bus_write(1'b0, 8'h20);
      master_start(8'h11, 8'h55, 2);
      repeat (3) @(negedge clk);
      bus_write(1'b1, 8'hEE);
      read_check(1'b0, 8'hA0, "R7 collision set");
      wait (!m_busy);
      check(cap === 8'h11, "R7 write ignored", int'(cap), 'h11);
      read_check(1'b1, 8'h55, "R7 rx");
      repeat (4) @(negedge clk);
      read_check(1'b0, 8'hA0, "R7 sticky");
      bus_write(1'b0, 8'h20);
      read_check(1'b0, 8'h20, "R7 cleared");
      buf_pop();

      // slave with select
      bus_write(1'b0, 8'h24);
      repeat (4) @(negedge clk);
      check(sdo_oe === 1'b1 && sck_oe === 1'b0, "R11 slave oe", int'({sdo_oe, sck_oe}), 2);
      bus_write(1'b1, 8'h96);
      slave_bits(8'h4B, 8, 8, got);
      check(got === 8'h96, "R5 slave tx", int'(got), 'h96);
      read_check(1'b1, 8'h4B, "R5 slave rx");
      check(buf_full === 1'b1, "R5 slave full", int'(buf_full), 1);
      slave_bits(8'h22, 8, 8, got);
      read_check(1'b0, 8'h64, "R8 overflow set");
      read_check(1'b1, 8'h4B, "R8 buffer kept");
      buf_pop();
      bus_write(1'b0, 8'h24);
      slave_bits(8'h71, 8, 8, got);
      read_check(1'b1, 8'h71, "R8 after clear");
      read_check(1'b0, 8'h24, "R8 flag clear");
      buf_pop();

      // partial byte abandoned by select
      slave_bits(8'hFF, 3, 8, got);
      ss_n_i = 1'b1;
      repeat (5) @(negedge clk);
      check(sdo_oe === 1'b0, "R10 deselect oe", int'(sdo_oe), 0);
      ss_n_i = 1'b0;
      repeat (5) @(negedge clk);
      bus_write(1'b1, 8'h81);
      slave_bits(8'h5C, 8, 8, got);
      check(got === 8'h81, "R10 fresh tx", int'(got), 'h81);
      read_check(1'b1, 8'h5C, "R10 fresh rx");
      read_check(1'b0, 8'h24, "R10 no collision");
      buf_pop();

      // slave with select ignored, idle high
      bus_write(1'b0, 8'h00);
      sck_i = 1'b1; ss_n_i = 1'b1;
      repeat (5) @(negedge clk);
      bus_write(1'b0, 8'h35);
      repeat (5) @(negedge clk);
      check(sdo_oe === 1'b1 && sck_oe === 1'b0, "R10 ss ignored oe", int'({sdo_oe, sck_oe}), 2);
      slave_bits(8'hE7, 8, 8, got);
      read_check(1'b1, 8'hE7, "R10 ss ignored rx");
      check(buf_full === 1'b1, "R10 ss ignored full", int'(buf_full), 1);
      buf_pop();

      // reserved mode
      bus_write(1'b0, 8'h00);
      sck_i = 1'b0; ss_n_i = 1'b0;
      repeat (5) @(negedge clk);
      bus_write(1'b0, 8'h27);
      repeat (4) @(negedge clk);
      check(sck_oe === 1'b0 && sdo_oe === 1'b0 && pins_en === 1'b0, "R12 pins",
            int'({sck_oe, sdo_oe, pins_en}), 0);
      bus_write(1'b1, 8'h55);
      slave_bits(8'h3A, 8, 8, got);
      check(buf_full === 1'b0, "R12 no transfer", int'(buf_full), 0);
      read_check(1'b0, 8'h27, "R12 no flags");

      // disabled
      bus_write(1'b0, 8'h04);
      repeat (4) @(negedge clk);
      check(sdo_oe === 1'b0 && pins_en === 1'b0 && sck_oe === 1'b0, "R11 disabled",
            int'({sck_oe, sdo_oe, pins_en}), 0);

      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule